// File: doc/BRIEF.md
# LUT-Based Distributed RAM

This block is a small random-access memory built from two 16-entry writable lookup-table lanes. Configuration inputs select how the lanes are organized: a single 16x1 memory, a 16x2 memory, a 32x1 memory, or a dual-port 16x1 memory. In dual-port mode a second, read-only port has its own address. Both lanes hold the same contents in that mode, and each lane serves one of the two read addresses.

Writes are synchronous. On the active edge of the write clock, the address, data and write enable are captured, and a single write into the selected lane entry follows from that edge. Reads are combinational from the address and need no clock. A second configuration input selects which clock edge is active. Reset loads a configuration-supplied initial image into the lanes.

Top module: `lut_dram`

## Requirements
- R1: `cfg_org` selects the organization: 2'b00 gives 16x1, 2'b01 gives 16x2, 2'b10 gives 32x1, and 2'b11 gives dual-port 16x1. `cfg_org` and `cfg_wclk_neg` change only while `rst_n` is low.
- R2: While `rst_n` is low, the contents are set from parameter `INIT`. In the three single-port organizations, lane 0 entry i takes INIT[i] and lane 1 entry i takes INIT[16+i]. In dual-port mode, both copies of entry i take INIT[i].
- R3: A write takes place only on an active write-clock edge where `we` is high. It stores the captured data at the captured address. With `we` low, no stored bit changes.
- R4: Reads are combinational. `spo` follows `addr`, and `dpo` follows `dpra`, with no clock edge needed. A read of the address just written shows the new data as soon as that edge has passed.
- R5: In 16x1, entry addr[3:0] is written with din[0] and read on spo[0]. spo[1] is 0, and addr[4] and din[1] have no effect.
- R6: In 16x2, entry addr[3:0] stores both din bits, and spo[1:0] returns them in the same bit order.
- R7: In 32x1, addr[4] selects the half: 0 selects lane 0 and 1 selects lane 1. A write into one half leaves the other half unchanged. din[0] is the stored bit, din[1] is ignored, and spo[1] is 0.
- R8: In dual-port mode, `addr` is both the write address and the address of `spo[0]`. `dpra` independently reads the same contents onto `dpo`. `dpo` is 0 in every other organization.
- R9: When `cfg_wclk_neg` is 0, the rising edge of `clk` writes. When it is 1, the falling edge writes and the rising edge does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the tile flip-flops |
| rst_n | input | 1 | Asynchronous active-low reset; loads the initial image |
| cfg_org | input | 2 | Organization select (static outside reset) |
| cfg_wclk_neg | input | 1 | 1: write on the falling clock edge |
| we | input | 1 | Write enable, captured on the active edge |
| din | input | 2 | Write data |
| addr | input | 5 | Write address and first-port read address |
| dpra | input | 4 | Dual-port read address |
| spo | output | 2 | First-port read data |
| dpo | output | 1 | Dual-port read data |

## Verification
A sequence of writes and reads runs under every organization. The sequence includes writes that carry data in the unused data bit, addresses with bit 4 set in organizations that should ignore it, and reads of one 32x1 half directly after a write to the other. These separate a correct lane decode from a swapped or shared one. Address sweeps with no clock edge show that reads are combinational and that the reset image lands in the right lanes, including the mirrored image in dual-port mode. A falling-edge run places a pending write across a rising edge and then a falling edge, which tells the two clock polarities apart.

// File: rtl/lut_dram_pkg.sv
`timescale 1ns/1ps
package lut_dram_pkg;

  localparam int LUT_AW    = 4;
  localparam int LUT_DEPTH = 1 << LUT_AW;
  localparam int NUM_LANES = 2;
  localparam int ADDR_W    = LUT_AW + 1;
  localparam int IMG_W     = NUM_LANES * LUT_DEPTH;

  typedef enum logic [1:0] {
    ORG_16X1   = 2'b00,
    ORG_16X2   = 2'b01,
    ORG_32X1   = 2'b10,
    ORG_DP16X1 = 2'b11
  } org_e;

  // Which lanes take the write pulse for the current organization.
  function automatic logic [NUM_LANES-1:0] lane_wr_sel(org_e org, logic we, logic hi);
    logic [NUM_LANES-1:0] sel;
    case (org)
      ORG_16X1: sel = {1'b0, we};
      ORG_16X2: sel = {we, we};
      ORG_32X1: sel = {we & hi, we & ~hi};
      default:  sel = {we, we};
    endcase
    return sel;
  endfunction

  // Data bit routed to each lane.
  function automatic logic [NUM_LANES-1:0] lane_wr_data(org_e org, logic [NUM_LANES-1:0] din);
    logic [NUM_LANES-1:0] d;
    if (org == ORG_16X2) d = din;
    else                 d = {din[0], din[0]};
    return d;
  endfunction

  // Reset image of one lane; the dual-port copy mirrors lane 0.
  function automatic logic [LUT_DEPTH-1:0] lane_init(org_e org, logic [IMG_W-1:0] img, int lane);
    logic [LUT_DEPTH-1:0] v;
    if (org == ORG_DP16X1) v = img[LUT_DEPTH-1:0];
    else                   v = img[lane*LUT_DEPTH +: LUT_DEPTH];
    return v;
  endfunction

  // Read address of one lane.
  function automatic logic [LUT_AW-1:0] lane_raddr(org_e org, int lane,
                                                   logic [LUT_AW-1:0] a, logic [LUT_AW-1:0] dpa);
    logic [LUT_AW-1:0] r;
    if (org == ORG_DP16X1 && lane == 1) r = dpa;
    else                                r = a;
    return r;
  endfunction

  // First-port output word.
  function automatic logic [NUM_LANES-1:0] sp_word(org_e org, logic hi, logic [NUM_LANES-1:0] q);
    logic [NUM_LANES-1:0] o;
    case (org)
      ORG_16X2: o = q;
      ORG_32X1: o = {1'b0, (hi ? q[1] : q[0])};
      default:  o = {1'b0, q[0]};
    endcase
    return o;
  endfunction

  // Dual-port output bit.
  function automatic logic dp_bit(org_e org, logic q1);
    return (org == ORG_DP16X1) ? q1 : 1'b0;
  endfunction

endpackage

// File: rtl/lut_dram_wr_dec.sv
`timescale 1ns/1ps
module lut_dram_wr_dec
  import lut_dram_pkg::*;
(
  input  org_e                 org,
  input  logic                 we,
  input  logic                 hi,
  input  logic [NUM_LANES-1:0] din,
  output logic [NUM_LANES-1:0] lane_wr,
  output logic [NUM_LANES-1:0] lane_wd
);

  always_comb begin
    lane_wr = lane_wr_sel(org, we, hi);
    lane_wd = lane_wr_data(org, din);
  end

endmodule

// File: rtl/lut_dram_lane.sv
`timescale 1ns/1ps
module lut_dram_lane #(
  parameter int AW = 4
) (
  input  logic                 wclk,
  input  logic                 rst_n,
  input  logic [(1<<AW)-1:0]   rst_val,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wa,
  input  logic                 wd,
  input  logic [AW-1:0]        ra,
  output logic                 q,
  output logic [(1<<AW)-1:0]   mem_o
);

  localparam int DEPTH = 1 << AW;

  logic [DEPTH-1:0] mem;

  // Edge-captured write: address, data and enable are sampled on wclk.
  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n)     mem     <= rst_val;
    else if (wr_en) mem[wa] <= wd;
  end

  // Combinational read path.
  assign q     = mem[ra];
  assign mem_o = mem;

  // R3
  wr_lands_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    wr_en |=> mem[$past(wa)] == $past(wd));

  // R3
  idle_hold_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    !wr_en |=> $stable(mem));

endmodule

// File: rtl/lut_dram_rd_sel.sv
`timescale 1ns/1ps
module lut_dram_rd_sel
  import lut_dram_pkg::*;
(
  input  org_e                 org,
  input  logic                 hi,
  input  logic [NUM_LANES-1:0] lane_q,
  output logic [NUM_LANES-1:0] spo,
  output logic                 dpo
);

  always_comb begin
    spo = sp_word(org, hi, lane_q);
    dpo = dp_bit(org, lane_q[1]);
  end

endmodule

// File: rtl/lut_dram.sv
`timescale 1ns/1ps
module lut_dram
  import lut_dram_pkg::*;
#(
  parameter logic [IMG_W-1:0] INIT = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           cfg_org,
  input  logic                 cfg_wclk_neg,
  input  logic                 we,
  input  logic [NUM_LANES-1:0] din,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [LUT_AW-1:0]    dpra,
  output logic [NUM_LANES-1:0] spo,
  output logic                 dpo
);

  org_e                 org;
  logic                 wclk;
  logic                 hi;
  logic [NUM_LANES-1:0] lane_wr;
  logic [NUM_LANES-1:0] lane_wd;
  logic [NUM_LANES-1:0] lane_q;
  logic [LUT_DEPTH-1:0] lane_mem [NUM_LANES];

  assign org  = org_e'(cfg_org);
  assign hi   = addr[ADDR_W-1];
  // Write clock polarity is chosen independently of the flip-flop clock.
  assign wclk = clk ^ cfg_wclk_neg;

  lut_dram_wr_dec u_wr_dec (
    .org     (org),
    .we      (we),
    .hi      (hi),
    .din     (din),
    .lane_wr (lane_wr),
    .lane_wd (lane_wd)
  );

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic [LUT_DEPTH-1:0] rv;
    logic [LUT_AW-1:0]    ra;
    assign rv = lane_init(org, INIT, g);
    assign ra = lane_raddr(org, g, addr[LUT_AW-1:0], dpra);

    lut_dram_lane #(.AW(LUT_AW)) u_lane (
      .wclk    (wclk),
      .rst_n   (rst_n),
      .rst_val (rv),
      .wr_en   (lane_wr[g]),
      .wa      (addr[LUT_AW-1:0]),
      .wd      (lane_wd[g]),
      .ra      (ra),
      .q       (lane_q[g]),
      .mem_o   (lane_mem[g])
    );
  end

  lut_dram_rd_sel u_rd_sel (
    .org    (org),
    .hi     (hi),
    .lane_q (lane_q),
    .spo    (spo),
    .dpo    (dpo)
  );

  // R8
  dp_mirror_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    (org == ORG_DP16X1) |-> (lane_mem[0] == lane_mem[1]));

  // R8
  dpo_quiet_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    (org != ORG_DP16X1) |-> (dpo == 1'b0));

  // R5 and R7
  upper_quiet_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    (org == ORG_16X1 || org == ORG_32X1) |-> (spo[1] == 1'b0));

  // R7
  lo_half_iso_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    (org == ORG_32X1 && we && hi) |=> $stable(lane_mem[0]));

  // R7
  hi_half_iso_chk: assert property (@(posedge wclk) disable iff (!rst_n)
    (org == ORG_32X1 && we && !hi) |=> $stable(lane_mem[1]));

endmodule

// File: tb/lut_dram_tb.sv
`timescale 1ns/1ps
module lut_dram_tb;

  localparam logic [31:0] INIT_V = 32'h1234_8421;
  localparam int NV = 25;

  typedef struct packed {
    logic [1:0] org;
    logic       we;
    logic [4:0] addr;
    logic [1:0] din;
    logic [3:0] dpra;
    logic [2:0] exp;   // {dpo, spo}
  } vec_t;

  // Groups of rows share an organization; a change of organization resets.
  localparam vec_t TBL [NV] = '{
    '{2'b00, 1'b0, 5'h00, 2'b00, 4'h0, 3'b001},
    '{2'b00, 1'b0, 5'h03, 2'b00, 4'h0, 3'b000},
    '{2'b00, 1'b1, 5'h03, 2'b11, 4'h0, 3'b001},
    '{2'b00, 1'b0, 5'h03, 2'b00, 4'h0, 3'b001},
    '{2'b00, 1'b1, 5'h05, 2'b00, 4'h0, 3'b000},
    '{2'b00, 1'b0, 5'h10, 2'b00, 4'h0, 3'b001},
    '{2'b01, 1'b0, 5'h02, 2'b00, 4'h0, 3'b010},
    '{2'b01, 1'b0, 5'h05, 2'b00, 4'h0, 3'b011},
    '{2'b01, 1'b1, 5'h05, 2'b01, 4'h0, 3'b001},
    '{2'b01, 1'b1, 5'h00, 2'b10, 4'h0, 3'b010},
    '{2'b01, 1'b0, 5'h04, 2'b00, 4'h0, 3'b010},
    '{2'b01, 1'b0, 5'h05, 2'b00, 4'h0, 3'b001},
    '{2'b10, 1'b0, 5'h02, 2'b00, 4'h0, 3'b000},
    '{2'b10, 1'b0, 5'h12, 2'b00, 4'h0, 3'b001},
    '{2'b10, 1'b1, 5'h05, 2'b00, 4'h0, 3'b000},
    '{2'b10, 1'b0, 5'h15, 2'b00, 4'h0, 3'b001},
    '{2'b10, 1'b1, 5'h17, 2'b01, 4'h0, 3'b001},
    '{2'b10, 1'b0, 5'h07, 2'b00, 4'h0, 3'b000},
    '{2'b10, 1'b1, 5'h0F, 2'b10, 4'h0, 3'b000},
    '{2'b11, 1'b0, 5'h00, 2'b00, 4'h5, 3'b101},
    '{2'b11, 1'b0, 5'h01, 2'b00, 4'h2, 3'b000},
    '{2'b11, 1'b1, 5'h02, 2'b01, 4'h2, 3'b101},
    '{2'b11, 1'b1, 5'h05, 2'b00, 4'hA, 3'b100},
    '{2'b11, 1'b0, 5'h07, 2'b00, 4'h5, 3'b000},
    '{2'b11, 1'b0, 5'h10, 2'b00, 4'h0, 3'b101}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] cfg_org;
  logic       cfg_wclk_neg;
  logic       we;
  logic [1:0] din;
  logic [4:0] addr;
  logic [3:0] dpra;
  logic [1:0] spo;
  logic       dpo;

  int n_chk = 0;
  int n_bad = 0;
  bit reported = 1'b0;

  always #2 clk = ~clk;

  lut_dram #(.INIT(INIT_V)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_org      (cfg_org),
    .cfg_wclk_neg (cfg_wclk_neg),
    .we           (we),
    .din          (din),
    .addr         (addr),
    .dpra         (dpra),
    .spo          (spo),
    .dpo          (dpo)
  );

  task automatic check(string tag, logic [2:0] act, logic [2:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {dpo,spo} got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    end
  endtask

  task automatic do_reset(logic [1:0] org, logic neg);
    rst_n        = 1'b0;
    we           = 1'b0;
    cfg_org      = org;
    cfg_wclk_neg = neg;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  function automatic string row_tag(logic [1:0] o, logic w);
    string s;
    case (o)
      2'b00:   s = "R5";
      2'b01:   s = "R6";
      2'b10:   s = "R7";
      default: s = "R8";
    endcase
    s = {s, " R1"};
    if (w) s = {s, " R3 R4"};
    else   s = {s, " R3"};
    return s;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    report();
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_org = 2'b00; cfg_wclk_neg = 1'b0;
    we = 1'b0; din = 2'b00; addr = '0; dpra = '0;

    // Vector table, positive write-clock polarity.
    for (int i = 0; i < NV; i++) begin
      if (i == 0 || TBL[i].org != TBL[i-1].org) do_reset(TBL[i].org, 1'b0);
      @(negedge clk);
      #1;
      we = TBL[i].we; addr = TBL[i].addr; din = TBL[i].din; dpra = TBL[i].dpra;
      @(posedge clk);
      #1 check($sformatf("%s row %0d", row_tag(TBL[i].org, TBL[i].we), i),
               {dpo, spo}, TBL[i].exp);
    end

    // R2 reset image in 16x2, swept with no clock edge (also R4).
    do_reset(2'b01, 1'b0);
    for (int a = 0; a < 16; a++) begin
      addr = 5'(a);
      #0.2 check($sformatf("R2 R4 16x2 image addr %0d", a), {dpo, spo},
                 {1'b0, INIT_V[16+a], INIT_V[a]});
    end

    // R2 mirrored image in dual-port mode, read on the second port.
    do_reset(2'b11, 1'b0);
    addr = 5'h00;
    for (int a = 0; a < 16; a++) begin
      dpra = 4'(a);
      #0.2 check($sformatf("R2 R8 dual-port image dpra %0d", a), {dpo, spo},
                 {INIT_V[a], 1'b0, INIT_V[0]});
    end

    // R2 reset discards earlier writes.
    do_reset(2'b00, 1'b0);
    @(negedge clk);
    #1 we = 1'b1; addr = 5'h04; din = 2'b01;
    @(posedge clk);
    #1 check("R3 write before reset", {dpo, spo}, 3'b001);
    do_reset(2'b00, 1'b0);
    addr = 5'h04;
    #0.2 check("R2 reset restores image", {dpo, spo}, {2'b00, INIT_V[4]});

    // R9 falling-edge polarity.
    do_reset(2'b00, 1'b1);
    we = 1'b1; addr = 5'h03; din = 2'b01;
    #1 check("R9 no write before falling edge", {dpo, spo}, 3'b000);
    @(negedge clk);
    #1 check("R9 falling edge writes", {dpo, spo}, 3'b001);
    we = 1'b1; addr = 5'h06; din = 2'b01;
    @(posedge clk);
    #1 check("R9 rising edge does not write", {dpo, spo}, 3'b000);
    we = 1'b0;
    @(negedge clk);
    #1 check("R9 no write with we low", {dpo, spo}, 3'b000);

    report();
    $finish;
  end

endmodule